// File: doc/BRIEF.md
# BCD Timekeeping Register Bank

This block is the time-of-day register file of a real-time clock. It holds eight byte-wide registers: a control byte, seconds, minutes, hours, a weekday byte that also carries a century flag, day of month, month and a two-digit year. Software sees every time value in packed BCD. Inside, the block keeps the values as binary counters and advances them by one second on each pulse of a one-cycle `sec_tick` strobe. That strobe comes from a prescaler outside the block.

Access goes through a single byte port with a 3-bit register index. Reads are combinational from the held state. A write lands on the clock edge. A write is range-checked against the field it targets, and a value out of range leaves that field untouched without any error. Bit 7 of the seconds byte is a stop flag that freezes counting. The year is kept as an offset from the parameter `BASE_YEAR`, and leap years are derived from that offset.

Top module: `rtc_bcd_bank`

## Requirements
- R1: After reset the eight registers read, by index 0..7: 0x90, 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00. The index map is 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year.
- R2: A write of value v to the control register (index 0) stores (v AND 0x5F) OR 0x90. Bit 7 and bit 4 therefore always read 1, and bit 5 always reads 0.
- R3: A seconds write always stores v[7] as the stop flag. It takes the binary value 10*v[6:4]+v[3:0] and loads it into the seconds only if that value is at most 59. A seconds read returns {stop flag, seconds in BCD}.
- R4: While the stop flag is 1, `sec_tick` changes no time field. After the flag is cleared, counting resumes from the frozen value.
- R5: A minutes write uses v[6:0] and an hours write uses v[5:0], each converted as 10*(upper digit)+(lower digit). Minutes are accepted for values 0..59 and hours for values 0..23. Any other value leaves the register unchanged.
- R6: A write to index 4 stores v[2:0] as the weekday and v[6] as the century bit. A read returns the century bit in bit 6 and the weekday in bits 2:0, with all other bits zero.
- R7: A date write uses v[5:0] and is ignored when its value is zero. A month write uses v[4:0] and is accepted only for values 1..12.
- R8: A year write uses all eight bits and is accepted only for values 0..99. The year reads back as the BCD offset from `BASE_YEAR`.
- R9: A tick with the stop flag clear adds one second. Seconds at 59 wrap to 0 and carry into minutes, minutes at 59 carry into hours, and hours at 23 carry into the date.
- R10: A date carry at the last day of the month sets the date to 1 and advances the month. The last day is 30 for April, June, September and November, 31 for the other 30/31-day months, and for February 29 when BASE_YEAR+year is divisible by 4, otherwise 28.
- R11: On each date carry the weekday advances by one, and 7 is followed by 1. December rolls over to January and increments the year modulo 100, so 99 is followed by 00.
- R12: When a write and a tick fall in the same cycle, the tick is applied first and then the write overrides the field it targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe for the indexed register |
| reg_idx | input | 3 | Register index for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the indexed register |

## Verification
The assertions assume that `reg_idx` is held steady from the cycle of a write or tick into the following cycle whenever the result is to be compared. The freeze and rejected-write properties only draw a conclusion while the index still points at the same register. The stimulus changes the index only on falling edges and leaves it in place across each write and the read that follows. Ticks are single-cycle pulses spaced apart, and each byte sweep writes all 256 values to one register with no tick in between.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 3;

    localparam logic [IDX_W-1:0] REG_CTRL  = 3'd0;
    localparam logic [IDX_W-1:0] REG_SEC   = 3'd1;
    localparam logic [IDX_W-1:0] REG_MIN   = 3'd2;
    localparam logic [IDX_W-1:0] REG_HOUR  = 3'd3;
    localparam logic [IDX_W-1:0] REG_WDAY  = 3'd4;
    localparam logic [IDX_W-1:0] REG_DATE  = 3'd5;
    localparam logic [IDX_W-1:0] REG_MONTH = 3'd6;
    localparam logic [IDX_W-1:0] REG_YEAR  = 3'd7;

    localparam logic [DATA_W-1:0] CTRL_CLR_MASK = 8'h5F;
    localparam logic [DATA_W-1:0] CTRL_SET_BITS = 8'h90;

    typedef struct packed {
        logic [7:0] ctrl;
        logic       stop;
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] wday;
        logic       cent;
        logic [5:0] date;
        logic [3:0] month;
        logic [6:0] year;
    } rtc_state_t;

    // two BCD digits to binary, digits above 9 weighted arithmetically
    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len #(
    parameter int BASE_YEAR = 2000
) (
    input  logic [3:0] month,
    input  logic [6:0] year,
    output logic [5:0] last_day
);
    logic [15:0] full_year;
    logic        leap;

    always_comb begin
        full_year = 16'(BASE_YEAR) + 16'(year);
        leap      = (full_year[1:0] == 2'b00);
        case (month)
            4'd2:                     last_day = leap ? 6'd29 : 6'd28;
            4'd4, 4'd6, 4'd9, 4'd11:  last_day = 6'd30;
            default:                  last_day = 6'd31;
        endcase
    end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_bank_pkg::*;
#(
    parameter int BASE_YEAR = 2000
) (
    input  rtc_state_t cur,
    output rtc_state_t nxt
);
    logic [5:0] last_day;

    rtc_month_len #(.BASE_YEAR(BASE_YEAR)) u_len (
        .month    (cur.month),
        .year     (cur.year),
        .last_day (last_day)
    );

    always_comb begin
        nxt = cur;
        if (cur.sec >= 6'd59) begin
            nxt.sec = 6'd0;
            if (cur.min >= 6'd59) begin
                nxt.min = 6'd0;
                if (cur.hour >= 5'd23) begin
                    nxt.hour = 5'd0;
                    nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    if (cur.date >= last_day) begin
                        nxt.date = 6'd1;
                        if (cur.month >= 4'd12) begin
                            nxt.month = 4'd1;
                            nxt.year  = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
                        end else begin
                            nxt.month = cur.month + 4'd1;
                        end
                    end else begin
                        nxt.date = cur.date + 6'd1;
                    end
                end else begin
                    nxt.hour = cur.hour + 5'd1;
                end
            end else begin
                nxt.min = cur.min + 6'd1;
            end
        end else begin
            nxt.sec = cur.sec + 6'd1;
        end
    end
endmodule

// File: rtl/rtc_write_decode.sv
module rtc_write_decode
    import rtc_bank_pkg::*;
(
    input  rtc_state_t              base,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        reg_idx,
    input  logic [DATA_W-1:0]       wr_data,
    output rtc_state_t              result
);
    logic [7:0] val;

    always_comb begin
        result = base;
        val    = 8'd0;
        if (wr_en) begin
            case (reg_idx)
                REG_CTRL: result.ctrl = (wr_data & CTRL_CLR_MASK) | CTRL_SET_BITS;
                REG_SEC: begin
                    result.stop = wr_data[7];
                    val = bcd_to_bin({1'b0, wr_data[6:0]});
                    if (val <= 8'd59) result.sec = val[5:0];
                end
                REG_MIN: begin
                    val = bcd_to_bin({1'b0, wr_data[6:0]});
                    if (val <= 8'd59) result.min = val[5:0];
                end
                REG_HOUR: begin
                    val = bcd_to_bin({2'b0, wr_data[5:0]});
                    if (val <= 8'd23) result.hour = val[4:0];
                end
                REG_WDAY: begin
                    result.wday = wr_data[2:0];
                    result.cent = wr_data[6];
                end
                REG_DATE: begin
                    val = bcd_to_bin({2'b0, wr_data[5:0]});
                    if (val != 8'd0) result.date = val[5:0];
                end
                REG_MONTH: begin
                    val = bcd_to_bin({3'b0, wr_data[4:0]});
                    if (val >= 8'd1 && val <= 8'd12) result.month = val[3:0];
                end
                default: begin
                    val = bcd_to_bin(wr_data);
                    if (val <= 8'd99) result.year = val[6:0];
                end
            endcase
        end
    end
endmodule

// File: rtl/rtc_bcd_bank.sv
module rtc_bcd_bank
    import rtc_bank_pkg::*;
#(
    parameter int BASE_YEAR = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              wr_en,
    input  logic [2:0]        reg_idx,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);
    localparam rtc_state_t RESET_STATE = '{
        ctrl: CTRL_SET_BITS, stop: 1'b0, sec: 6'd0, min: 6'd0, hour: 5'd0,
        wday: 3'd1, cent: 1'b0, date: 6'd1, month: 4'd1, year: 7'd0
    };

    rtc_state_t state_q;
    rtc_state_t state_d;
    rtc_state_t advanced;
    rtc_state_t ticked;
    rtc_state_t written;

    rtc_advance #(.BASE_YEAR(BASE_YEAR)) u_adv (
        .cur (state_q),
        .nxt (advanced)
    );

    rtc_write_decode u_wr (
        .base    (ticked),
        .wr_en   (wr_en),
        .reg_idx (reg_idx),
        .wr_data (wr_data),
        .result  (written)
    );

    always_comb begin
        ticked  = (sec_tick && !state_q.stop) ? advanced : state_q;
        state_d = written;
        case (reg_idx)
            REG_CTRL:  rd_data = state_q.ctrl;
            REG_SEC:   rd_data = {state_q.stop, bin_to_bcd({1'b0, state_q.sec})}[7:0] | 8'h00;
            REG_MIN:   rd_data = bin_to_bcd({1'b0, state_q.min});
            REG_HOUR:  rd_data = bin_to_bcd({2'b0, state_q.hour});
            REG_WDAY:  rd_data = {1'b0, state_q.cent, 3'b000, state_q.wday};
            REG_DATE:  rd_data = bin_to_bcd({1'b0, state_q.date});
            REG_MONTH: rd_data = bin_to_bcd({3'b0, state_q.month});
            default:   rd_data = bin_to_bcd(state_q.year);
        endcase
        if (reg_idx == REG_SEC) begin
            rd_data[7] = state_q.stop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RESET_STATE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/rtc_bcd_bank_chk.sv
module rtc_bcd_bank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       wr_en,
    input logic [2:0] reg_idx,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data
);
    logic [7:0] min_val;
    assign min_val = 8'(wr_data[6:4]) * 8'd10 + 8'(wr_data[3:0]);

    // R2
    ctrl_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 3'd0) |-> (rd_data[7] && rd_data[4] && !rd_data[5]));

    // R3
    sec_bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 3'd1) |-> (rd_data[3:0] <= 4'd9 && rd_data[6:4] <= 3'd5));

    // R4
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 3'd1 && rd_data[7] && !wr_en)
        |=> (reg_idx != 3'd1) || (rd_data == $past(rd_data)));

    // R5
    min_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sec_tick && reg_idx == 3'd2 && min_val > 8'd59)
        |=> (reg_idx != 3'd2) || (rd_data == $past(rd_data)));

    // R5
    hour_bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 3'd3) |-> (rd_data[7:6] == 2'b00 && rd_data[3:0] <= 4'd9 &&
                               (rd_data[5:4] < 2'd2 || rd_data[3:0] <= 4'd3)));

    // R9
    tick_moves_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 3'd1 && !rd_data[7] && sec_tick && !wr_en)
        |=> (reg_idx != 3'd1) || (rd_data != $past(rd_data)));

    // R7
    month_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == 3'd6) |-> ((rd_data[7:4] == 4'd0 && rd_data[3:0] >= 4'd1 && rd_data[3:0] <= 4'd9) ||
                               (rd_data >= 8'h10 && rd_data <= 8'h12)));
endmodule

bind rtc_bcd_bank rtc_bcd_bank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .wr_en    (wr_en),
    .reg_idx  (reg_idx),
    .wr_data  (wr_data),
    .rd_data  (rd_data)
);

// File: tb/rtc_bcd_bank_bench.sv
module rtc_bcd_bank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] reg_idx = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rtc_bcd_bank #(.BASE_YEAR(2000)) u_rtc_bcd_bank (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
        .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    function automatic int bcdv(input int b);
        return ((b >> 4) & 15) * 10 + (b & 15);
    endfunction

    function automatic int tob(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int mlen(input int mo, input int y);
        if (mo == 2) return ((2000 + y) % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic check(input logic [7:0] act, input int exp, input string req);
        checks++;
        if (act !== exp[7:0]) begin
            errors++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp[7:0]);
        end
    endtask

    task automatic wr(input int idx, input int v);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = idx[2:0]; wr_data = v[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [7:0] d);
        @(negedge clk);
        reg_idx = idx[2:0];
        #1 d = rd_data;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic set_time(input int h, input int m, input int s, input int wd,
                            input int d, input int mo, input int y);
        wr(7, tob(y)); wr(6, tob(mo)); wr(5, tob(d)); wr(4, wd);
        wr(3, tob(h)); wr(2, tob(m)); wr(1, tob(s));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int rst_vals[8] = '{8'h90, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
        int ctrl, sec, stp, mn, hr, wd, cen, dt, mo, yr, val, exp;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd(i, d); check(d, rst_vals[i], "R1 reset value");
        end

        ctrl = 8'h90; sec = 0; stp = 0; mn = 0; hr = 0; wd = 1; cen = 0; dt = 1; mo = 1; yr = 0;

        // R2 R3 R5 R6 R7 R8: all byte values into each register
        for (int r = 0; r < 8; r++) begin
            for (int v = 0; v < 256; v++) begin
                wr(r, v);
                case (r)
                    0: begin ctrl = (v & 8'h5F) | 8'h90; exp = ctrl; end
                    1: begin
                        stp = (v >> 7) & 1; val = bcdv(v & 8'h7F);
                        if (val <= 59) sec = val;
                        exp = (stp << 7) | tob(sec);
                    end
                    2: begin val = bcdv(v & 8'h7F); if (val <= 59) mn = val; exp = tob(mn); end
                    3: begin val = bcdv(v & 8'h3F); if (val <= 23) hr = val; exp = tob(hr); end
                    4: begin wd = v & 7; cen = (v >> 6) & 1; exp = (cen << 6) | wd; end
                    5: begin val = bcdv(v & 8'h3F); if (val != 0) dt = val; exp = tob(dt); end
                    6: begin val = bcdv(v & 8'h1F); if (val >= 1 && val <= 12) mo = val; exp = tob(mo); end
                    default: begin val = bcdv(v); if (val <= 99) yr = val; exp = tob(yr); end
                endcase
                rd(r, d);
                case (r)
                    0: check(d, exp, "R2 control forced bits");
                    1: check(d, exp, "R3 seconds write/stop");
                    2, 3: check(d, exp, "R5 minutes/hours range");
                    4: check(d, exp, "R6 weekday/century");
                    5, 6: check(d, exp, "R7 date/month range");
                    default: check(d, exp, "R8 year range");
                endcase
            end
        end
        wr(1, 8'h00);

        // R4: stop freezes, clearing resumes
        wr(1, 8'hB0);
        repeat (3) tick();
        rd(1, d); check(d, 8'hB0, "R4 frozen while stopped");
        wr(1, 8'h7F);
        rd(1, d); check(d, 8'h30, "R4 stop cleared, invalid seconds kept");
        tick();
        rd(1, d); check(d, 8'h31, "R4 resumes from frozen value");

        // R9: carry chain up to hours
        set_time(10, 59, 59, 2, 15, 6, 20);
        tick();
        rd(1, d); check(d, 8'h00, "R9 seconds wrap");
        rd(2, d); check(d, 8'h00, "R9 minutes wrap");
        rd(3, d); check(d, 8'h11, "R9 hour carry");
        rd(5, d); check(d, 8'h15, "R9 date unchanged");

        // R10 R11: month ends, leap and common years
        for (int yi = 0; yi < 2; yi++) begin
            for (int m = 1; m <= 12; m++) begin
                int y = (yi == 0) ? 4 : 5;
                set_time(23, 59, 59, 3, mlen(m, y), m, y);
                tick();
                rd(5, d); check(d, 8'h01, "R10 date wraps at month end");
                rd(6, d); check(d, tob((m == 12) ? 1 : m + 1), "R10 month advances");
                rd(7, d); check(d, tob((m == 12) ? y + 1 : y), "R11 year on December");
                rd(4, d); check(d, 8'h04, "R11 weekday advances");
                rd(3, d); check(d, 8'h00, "R9 hours wrap");
            end
        end
        set_time(23, 59, 59, 1, 28, 2, 8);
        tick();
        rd(5, d); check(d, 8'h29, "R10 leap February 29");

        // R11: weekday 7 -> 1, year 99 -> 00
        set_time(23, 59, 59, 7, 31, 12, 99);
        tick();
        rd(4, d); check(d, 8'h01, "R11 weekday 7 to 1");
        rd(7, d); check(d, 8'h00, "R11 year 99 to 00");
        rd(6, d); check(d, 8'h01, "R11 December to January");

        // R12: write and tick together
        set_time(10, 20, 59, 2, 5, 5, 30);
        @(negedge clk);
        wr_en = 1'b1; reg_idx = 3'd2; wr_data = 8'h45; sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
        rd(2, d); check(d, 8'h45, "R12 write overrides ticked minutes");
        rd(1, d); check(d, 8'h00, "R12 tick still applied to seconds");
        rd(3, d); check(d, 8'h10, "R12 hours untouched");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule